// File: doc/BRIEF.md
# Dead-Time Current-Sense Correction Selector

This block serves a three-phase inverter in which each phase is a complementary pair of high-side and low-side switches. Dead-time distorts the voltage a phase delivers, and the size of that error depends on the direction of the load current. To offset it, each phase keeps two duty values. The block decides, phase by phase, which of the two is applied at the next duty reload. It does not generate the PWM waveform. It watches the gate states and counter position that the PWM generator produces.

A two-bit method input chooses where each phase's correction polarity comes from. Codes 00 and 01 use a software polarity bit per phase and do no sensing. Code 10 latches the phase's current-sense pin while both switches of the pair are off. Code 11 latches the sense pin at one point in the PWM period. In center-aligned mode that point is the counter peak. In edge-aligned mode it is the counter wrap. The method input is not buffered, so a change takes effect on the next clock, even partway through a PWM period.

At every duty-update pulse, the selected polarity and the duty value it picks are registered to the outputs. Between pulses the outputs hold their values.

Top module: `deadtime_corr_sel`

## Requirements
- R1: While `rst` is high, at the next rising edge every bit of `corr_pol` and `duty_out` becomes 0, and every phase's latched sense sample becomes 0.
- R2: With `method` equal to 2'b00 or 2'b01, a `duty_upd` clock loads `corr_pol[i]` with `sw_pol[i]` as it stands on that clock.
- R3: With `method` equal to 2'b10, on any clock where `top_on[i]` and `bot_on[i]` are both 0, phase i latches `sense[i]`.
- R4: With `method` equal to 2'b10, on a clock where `top_on[i]` or `bot_on[i]` is 1, phase i keeps its latched sample. At 0% or 100% duty one switch is always on, so the sample never changes.
- R5: With `method` equal to 2'b11 and `center` equal to 1, every phase latches its sense pin on a clock where `count` equals `modulus`, whatever the gate states are.
- R6: With `method` equal to 2'b11 and `center` equal to 0, every phase latches its sense pin on a clock where `count` is less than its value on the previous clock (a wrap). The previous count is taken as 0 right after reset.
- R7: With `method[1]` equal to 1, a `duty_upd` clock loads `corr_pol[i]` with the phase's latched sample as it stood before that clock.
- R8: On each `duty_upd` clock, phase i's DW-bit field of `duty_out` (bits i*DW and up) loads `duty_odd` when the new `corr_pol[i]` is 1, and `duty_even` when it is 0. On a clock without `duty_upd`, `corr_pol` and `duty_out` do not change.
- R9: A change on `method` acts on the next clock, with no waiting for a period boundary or a duty update.
- R10: While `method[1]` is 0, the latched samples are not written. Sense values seen then have no effect when sensing resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| method | input | 2 | Correction method code (unbuffered) |
| center | input | 1 | 1 = center-aligned counter, 0 = edge-aligned |
| count | input | CW | Present PWM counter value |
| modulus | input | CW | PWM counter modulus |
| top_on | input | NPH | High-side gate on, one bit per phase |
| bot_on | input | NPH | Low-side gate on, one bit per phase |
| sense | input | NPH | Current-sense pin, one bit per phase |
| sw_pol | input | NPH | Software correction polarity, one bit per phase |
| duty_upd | input | 1 | Duty reload strobe |
| duty_even | input | NPH*DW | Duty used when polarity is 0, phase i in bits i*DW and up |
| duty_odd | input | NPH*DW | Duty used when polarity is 1, phase i in bits i*DW and up |
| corr_pol | output | NPH | Registered correction polarity per phase |
| duty_out | output | NPH*DW | Registered selected duty per phase |

## Verification
The hardest case to reach is a phase whose duty is pinned at 0% or 100% while dead-time sensing is active. Its sample must stay frozen even as the sense pin toggles, while a neighbouring phase at a normal duty keeps latching. A second hard case is a method change in the middle of a period, made when the latched sample and the software bit disagree. The bench gets there by running a real up/down or wrapping counter and deriving each phase's gates from its own duty threshold and a dead band. One phase's threshold is placed beyond the modulus, and the method is switched on cycles unrelated to the period boundaries. A behavioural model follows every clock and is compared with both outputs.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        M_SOFT_A   = 2'b00,
        M_SOFT_B   = 2'b01,
        M_DEADBAND = 2'b10,
        M_CYCPOINT = 2'b11
    } corr_mode_e;

    typedef struct packed {
        logic pol;
        logic smp;
    } phase_state_t;

    function automatic logic mode_senses(corr_mode_e m);
        return m[1];
    endfunction

    function automatic logic both_off(logic hi, logic lo);
        return !hi && !lo;
    endfunction

endpackage

// File: rtl/csc_cycle_tick.sv
module csc_cycle_tick #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          center,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] modulus,
    output logic          hit
);
    logic [CW-1:0] prev_q;
    logic          peak;
    logic          wrap;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= count;
    end

    always_comb begin
        peak = (count == modulus);
        wrap = (count < prev_q);
        hit  = center ? peak : wrap;
    end

endmodule

// File: rtl/csc_phase.sv
module csc_phase
    import csc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  corr_mode_e    mode,
    input  logic          hit,
    input  logic          top_on,
    input  logic          bot_on,
    input  logic          sense,
    input  logic          sw_pol,
    input  logic          upd,
    input  logic [DW-1:0] duty_even,
    input  logic [DW-1:0] duty_odd,
    output logic          pol_q,
    output logic [DW-1:0] duty_q
);
    phase_state_t st_q;
    logic         cap_en;
    logic         pick;

    always_comb begin
        unique case (mode)
            M_DEADBAND: cap_en = both_off(top_on, bot_on);
            M_CYCPOINT: cap_en = hit;
            default:    cap_en = 1'b0;
        endcase
        pick = mode_senses(mode) ? st_q.smp : sw_pol;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            duty_q <= '0;
        end else begin
            if (cap_en) st_q.smp <= sense;
            if (upd) begin
                st_q.pol <= pick;
                duty_q   <= pick ? duty_odd : duty_even;
            end
        end
    end

    assign pol_q = st_q.pol;

    p_reset_r1: assert property (@(posedge clk) $past(rst) |-> (pol_q == 1'b0 && duty_q == '0));

    p_soft_r2: assert property (@(posedge clk) disable iff (rst)
        (upd && !mode[1]) |=> (pol_q == $past(sw_pol)));

    p_dt_cap_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == M_DEADBAND && !top_on && !bot_on) |=> (st_q.smp == $past(sense)));

    p_dt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == M_DEADBAND && (top_on || bot_on)) |=> $stable(st_q.smp));

    p_cyc_cap_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == M_CYCPOINT && hit) |=> (st_q.smp == $past(sense)));

    p_duty_r8: assert property (@(posedge clk) disable iff (rst)
        upd |=> (duty_q == (pol_q ? $past(duty_odd) : $past(duty_even))));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(pol_q) && $stable(duty_q)));

    p_soft_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        !mode[1] |=> $stable(st_q.smp));

endmodule

// File: rtl/deadtime_corr_sel.sv
module deadtime_corr_sel
    import csc_pkg::*;
#(
    parameter int NPH = 3,
    parameter int CW  = 8,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        method,
    input  logic              center,
    input  logic [CW-1:0]     count,
    input  logic [CW-1:0]     modulus,
    input  logic [NPH-1:0]    top_on,
    input  logic [NPH-1:0]    bot_on,
    input  logic [NPH-1:0]    sense,
    input  logic [NPH-1:0]    sw_pol,
    input  logic              duty_upd,
    input  logic [NPH*DW-1:0] duty_even,
    input  logic [NPH*DW-1:0] duty_odd,
    output logic [NPH-1:0]    corr_pol,
    output logic [NPH*DW-1:0] duty_out
);
    localparam int DTOT = NPH * DW;

    corr_mode_e mode;
    logic       hit;

    assign mode = corr_mode_e'(method);

    csc_cycle_tick #(.CW(CW)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .center  (center),
        .count   (count),
        .modulus (modulus),
        .hit     (hit)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        csc_phase #(.DW(DW)) u_ph (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode),
            .hit       (hit),
            .top_on    (top_on[i]),
            .bot_on    (bot_on[i]),
            .sense     (sense[i]),
            .sw_pol    (sw_pol[i]),
            .upd       (duty_upd),
            .duty_even (duty_even[i*DW +: DW]),
            .duty_odd  (duty_odd[i*DW +: DW]),
            .pol_q     (corr_pol[i]),
            .duty_q    (duty_out[i*DW +: DW])
        );
    end

    p_width_r8: assert property (@(posedge clk) disable iff (rst)
        (duty_upd && !method[1]) |=> (duty_out[DTOT-1 -: DW] ==
            (corr_pol[NPH-1] ? $past(duty_odd[DTOT-1 -: DW]) : $past(duty_even[DTOT-1 -: DW]))));

endmodule

// File: tb/tb_deadtime_corr_sel.sv
module tb_deadtime_corr_sel;
    localparam int NPH = 3;
    localparam int CW  = 8;
    localparam int DW  = 8;
    localparam int MODV = 20;
    localparam int DB   = 2;

    logic              clk = 0;
    logic              rst;
    logic [1:0]        method;
    logic              center;
    logic [CW-1:0]     count;
    logic [CW-1:0]     modulus;
    logic [NPH-1:0]    top_on, bot_on, sense, sw_pol;
    logic              duty_upd;
    logic [NPH*DW-1:0] duty_even, duty_odd;
    logic [NPH-1:0]    corr_pol;
    logic [NPH*DW-1:0] duty_out;

    always #4 clk = ~clk;

    deadtime_corr_sel #(.NPH(NPH), .CW(CW), .DW(DW)) dut (.*);

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference
    bit          m_smp [NPH];
    bit          m_pol [NPH];
    int          m_duty[NPH];
    int          m_prev;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPH; i++) begin m_smp[i] = 0; m_pol[i] = 0; m_duty[i] = 0; end
            m_prev = 0;
        end else begin
            bit trig;
            bit old_smp [NPH];
            if (center) trig = (int'(count) == int'(modulus));
            else        trig = (int'(count) < m_prev);
            for (int i = 0; i < NPH; i++) old_smp[i] = m_smp[i];
            for (int i = 0; i < NPH; i++) begin
                if (method == 2'b10 && !top_on[i] && !bot_on[i]) m_smp[i] = sense[i];
                if (method == 2'b11 && trig) m_smp[i] = sense[i];
                if (duty_upd) begin
                    m_pol[i]  = method[1] ? old_smp[i] : sw_pol[i];
                    m_duty[i] = m_pol[i] ? int'(duty_odd[i*DW +: DW]) : int'(duty_even[i*DW +: DW]);
                end
            end
            m_prev = int'(count);
        end
    end

    task automatic compare();
        for (int i = 0; i < NPH; i++) begin
            total++;
            if (corr_pol[i] !== m_pol[i] || int'(duty_out[i*DW +: DW]) != m_duty[i]) begin
                bad++;
                $display("FAIL %s R8 phase %0d: pol=%0b duty=%0d expected pol=%0b duty=%0d",
                         tag, i, corr_pol[i], duty_out[i*DW +: DW], m_pol[i], m_duty[i]);
            end
        end
    endtask

    int bc = 0, dir = 1;
    int thr[NPH];

    task automatic run(int n, int mth, bit ctr, bit rand_method);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
            center = ctr;
            if (ctr) begin
                if (bc >= MODV) dir = -1; else if (bc <= 0) dir = 1;
                bc = bc + dir;
            end else begin
                bc = (bc >= MODV) ? 0 : bc + 1;
            end
            count    = CW'(bc);
            duty_upd = (bc == 0);
            for (int i = 0; i < NPH; i++) begin
                bot_on[i] = (bc < thr[i]);
                top_on[i] = (bc > thr[i] + DB);
            end
            sense  = NPH'($urandom);
            sw_pol = NPH'($urandom);
            if (duty_upd) begin
                duty_even = (NPH*DW)'({$urandom, $urandom});
                duty_odd  = (NPH*DW)'({$urandom, $urandom});
            end
            method = rand_method ? 2'($urandom) : 2'(mth);
        end
    endtask

    initial begin
        rst = 1; method = 0; center = 1; count = 0; modulus = CW'(MODV);
        top_on = 0; bot_on = 0; sense = '1; sw_pol = '1; duty_upd = 1;
        duty_even = '1; duty_odd = '1;
        thr[0] = 6; thr[1] = 10; thr[2] = 14;
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        rst = 0;
        tag = "R2"; run(120, 0, 1, 0);
        run(120, 1, 0, 0);
        tag = "R3 R7"; run(200, 2, 1, 0);
        tag = "R4"; thr[1] = MODV + 5; thr[2] = -5; run(200, 2, 1, 0);
        tag = "R5"; run(200, 3, 1, 0);
        tag = "R6"; thr[1] = 10; thr[2] = 14; run(200, 3, 0, 0);
        tag = "R10"; run(60, 0, 0, 0); thr[0] = MODV + 5; run(100, 2, 0, 0);
        tag = "R9"; thr[0] = 6; run(600, 0, 1, 1); run(600, 0, 0, 1);
        thr[2] = MODV + 5; run(400, 0, 1, 1);
        @(negedge clk); compare();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog %s: run did not end, expected completion", tag);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule